// File: doc/BRIEF.md
# Converter Output Pipeline and Recalibration Sequencer

This block is the digital back end of a pipelined analog-to-digital converter. On every sample clock it accepts an 8-bit offset-binary code and an over-range flag from the converter core. It carries them through a fixed pipeline of 28 sample clocks and presents them on an output data bus with a qualifying valid level, an over-range pin and an output-clock enable. The input clock can be used as the sample clock directly, or divided by two. A format select chooses offset-binary or two's-complement coding at the output.

An active-low reset input also serves as the recalibration request. While it is low, the output clock enable is forced low and the over-range pin is forced high. When it is released, a calibration interval of `CAL_CYCLES` sample clocks runs. The over-range pin stays high for the whole interval, so it also acts as a calibration-busy flag. Samples captured during calibration are marked invalid, so the data bus reads zero until 28 post-calibration samples have filled the pipeline. The block has no separate power-on input: the first release of the reset input starts the initial calibration.

The output stream has a valid level but no ready. A converter cannot be stalled, so the sink must take each sample on the cycle in which the output clock enable is high. Back-pressure is therefore not supported, and a sample that is not taken is lost.

Top module: `adc_backend_seq`

## Requirements
- R1: The sample code present at a sample edge appears on `data_out` once 28 sample edges have occurred, counting the capturing edge as the first. It then holds until the next sample edge.
- R2: While calibration is running, and until 28 samples captured after calibration have reached the output, `out_valid` is low and `data_out` is all zeros.
- R3: `ovr_out` goes high in the same instant that `rst_n` goes low. It stays high while `rst_n` is low and throughout calibration.
- R4: Calibration begins at the release of `rst_n` and lasts exactly `CAL_CYCLES` sample edges. Its end is the first point after which `ovr_out` can fall.
- R5: After calibration, `ovr_out` equals the over-range flag carried with the sample currently at the output, with the same 28-edge delay as the data. This applies to invalid samples captured during calibration as well. A set flag there keeps the pin high, so the end of calibration is not visible.
- R6: `out_clk_en` is low while `rst_n` is low. From the first clock edge after release it is high in every cycle whose next edge is a sample edge.
- R7: With `fmt_twos` = 0 the valid output is the offset-binary code unchanged. With `fmt_twos` = 1, bit 7 (the MSB) is inverted, which gives two's complement. Zeros shown during refill are not reformatted.
- R8: With `div2_en` = 1, sample edges fall on every second clock edge, starting with the second edge after release. Pipeline, calibration count and `out_clk_en` all follow that rate.
- R9: A low on `rst_n` lasting a single clock, applied at any time including the last cycle of calibration, aborts everything. The pipeline empties and the full calibration count restarts from the following release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low reset and recalibration request, asynchronous assert |
| div2_en | input | 1 | 1: sample clock is the input clock divided by two |
| fmt_twos | input | 1 | 1: two's-complement output, 0: offset binary |
| sample_code | input | 8 | Offset-binary code from the converter core |
| sample_ovr | input | 1 | Over-range flag of the current sample |
| data_out | output | 8 | Formatted output code, zero while invalid |
| out_valid | output | 1 | Output code is a post-calibration sample |
| ovr_out | output | 1 | Over-range of the output sample, or calibration busy |
| out_clk_en | output | 1 | Output clock enable, one pulse per sample edge |

## Verification
Two functions can fall in the same cycle. One is a recalibration request and the other is the final count of a running calibration. The bench provokes this by releasing reset, waiting one cycle short of `CAL_CYCLES`, and pulling `rst_n` low for a single clock. The result is judged on three points: `ovr_out` never drops, the pipeline stays invalid, and a full fresh count is needed after the second release. A second overlap is a sustained over-range input across the end of calibration, in which the data path and the busy indication share the pin. There, a behavioural model predicts the pin level on every clock.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic {
    FMT_OFFSET = 1'b0,
    FMT_TWOS   = 1'b1
  } out_fmt_e;

  function automatic logic [7:0] fmt_code(input logic [7:0] code, input out_fmt_e f);
    logic [7:0] r;
    r = code;
    if (f == FMT_TWOS) r[7] = ~code[7];
    return r;
  endfunction
endpackage

// File: rtl/adcseq_clkgen.sv
module adcseq_clkgen (
  input  logic clk,
  input  logic rst_n,
  input  logic div2_en,
  output logic smp_en,
  output logic out_clk_en
);
  logic phase_q;
  logic run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      phase_q <= ~phase_q;
      run_q   <= 1'b1;
    end
  end

  assign smp_en     = ~div2_en | phase_q;
  assign out_clk_en = run_q & smp_en;
endmodule

// File: rtl/adcseq_cal.sv
module adcseq_cal #(
  parameter int CAL_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_en,
  output logic cal_busy
);
  localparam int CNT_W = (CAL_CYCLES < 2) ? 1 : $clog2(CAL_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CAL_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (smp_en && busy_q) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cal_busy = busy_q;
endmodule

// File: rtl/adcseq_pipe.sv
module adcseq_pipe #(
  parameter int DATA_W  = 8,
  parameter int LATENCY = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_en,
  input  logic              in_valid,
  input  logic              in_ovr,
  input  logic [DATA_W-1:0] in_code,
  output logic              out_valid,
  output logic              out_ovr,
  output logic [DATA_W-1:0] out_code
);
  logic              vld_q  [LATENCY];
  logic              ovr_q  [LATENCY];
  logic [DATA_W-1:0] code_q [LATENCY];

  for (genvar i = 0; i < LATENCY; i++) begin : g_stage
    logic              nxt_v;
    logic              nxt_o;
    logic [DATA_W-1:0] nxt_c;
    if (i == 0) begin : g_head
      assign nxt_v = in_valid;
      assign nxt_o = in_ovr;
      assign nxt_c = in_code;
    end else begin : g_body
      assign nxt_v = vld_q[i-1];
      assign nxt_o = ovr_q[i-1];
      assign nxt_c = code_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[i]  <= 1'b0;
        ovr_q[i]  <= 1'b0;
        code_q[i] <= '0;
      end else if (smp_en) begin
        vld_q[i]  <= nxt_v;
        ovr_q[i]  <= nxt_o;
        code_q[i] <= nxt_c;
      end
    end
  end

  assign out_valid = vld_q[LATENCY-1];
  assign out_ovr   = ovr_q[LATENCY-1];
  assign out_code  = code_q[LATENCY-1];
endmodule

// File: rtl/adc_backend_seq.sv
module adc_backend_seq
  import adcseq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int LATENCY    = 28,
  parameter int CAL_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div2_en,
  input  logic              fmt_twos,
  input  logic [DATA_W-1:0] sample_code,
  input  logic              sample_ovr,
  output logic [DATA_W-1:0] data_out,
  output logic              out_valid,
  output logic              ovr_out,
  output logic              out_clk_en
);
  logic              smp_en;
  logic              cal_busy;
  logic              p_valid;
  logic              p_ovr;
  logic [DATA_W-1:0] p_code;

  adcseq_clkgen u_clk (
    .clk        (clk),
    .rst_n      (rst_n),
    .div2_en    (div2_en),
    .smp_en     (smp_en),
    .out_clk_en (out_clk_en)
  );

  adcseq_cal #(.CAL_CYCLES(CAL_CYCLES)) u_cal (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_en   (smp_en),
    .cal_busy (cal_busy)
  );

  adcseq_pipe #(.DATA_W(DATA_W), .LATENCY(LATENCY)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_en    (smp_en),
    .in_valid  (~cal_busy),
    .in_ovr    (sample_ovr),
    .in_code   (sample_code),
    .out_valid (p_valid),
    .out_ovr   (p_ovr),
    .out_code  (p_code)
  );

  always_comb begin
    data_out = '0;
    if (p_valid) begin
      data_out = p_code;
      if (fmt_twos) data_out[DATA_W-1] = ~p_code[DATA_W-1];
    end
  end

  assign out_valid = p_valid;
  assign ovr_out   = cal_busy | p_ovr;
endmodule

// File: rtl/adc_backend_seq_chk.sv
module adc_backend_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              div2_en,
  input logic [DATA_W-1:0] data_out,
  input logic              out_valid,
  input logic              ovr_out,
  input logic              out_clk_en,
  input logic              cal_busy
);
  always @(negedge clk) begin
    if (rst_n === 1'b0) begin
      AST_OVR_IN_RESET: assert (ovr_out);          // R3
      AST_CLK_LOW_IN_RESET: assert (!out_clk_en);  // R6
    end
  end

  AST_ZERO_WHEN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> data_out == '0);  // R2

  AST_NO_VALID_DURING_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> !out_valid);  // R2

  AST_CAL_FLAGS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> ovr_out);  // R3

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid);  // R1

  AST_CAL_NO_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_busy |=> !cal_busy);  // R4

  AST_DIV2_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    (div2_en && out_clk_en) |=> (!out_clk_en || !div2_en));  // R8
endmodule

bind adc_backend_seq adc_backend_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .div2_en    (div2_en),
  .data_out   (data_out),
  .out_valid  (out_valid),
  .ovr_out    (ovr_out),
  .out_clk_en (out_clk_en),
  .cal_busy   (cal_busy)
);

// File: tb/adc_backend_seq_test.sv
`timescale 1ns/1ps
module adc_backend_seq_test;
  localparam int LAT = 28;
  localparam int CAL = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       div2_en = 1'b0;
  logic       fmt_twos = 1'b0;
  logic [7:0] sample_code = 8'h00;
  logic       sample_ovr = 1'b0;
  logic [7:0] data_out;
  logic       out_valid;
  logic       ovr_out;
  logic       out_clk_en;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  adc_backend_seq #(.DATA_W(8), .LATENCY(LAT), .CAL_CYCLES(CAL)) uut (
    .clk(clk), .rst_n(rst_n), .div2_en(div2_en), .fmt_twos(fmt_twos),
    .sample_code(sample_code), .sample_ovr(sample_ovr),
    .data_out(data_out), .out_valid(out_valid), .ovr_out(ovr_out),
    .out_clk_en(out_clk_en)
  );

  // Behavioural reference: queue of {valid, ovr, code}, newest at front
  logic [9:0] q[$];
  bit m_phase, m_run, m_busy;
  int m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_run = 0; m_busy = 1; m_cnt = 0;
      q.delete();
    end else begin
      if (!div2_en || m_phase) begin
        q.push_front({!m_busy, sample_ovr, sample_code});
        if (q.size() > LAT) void'(q.pop_back());
        if (m_busy) begin
          m_cnt++;
          if (m_cnt == CAL) m_busy = 0;
        end
      end
      m_phase = !m_phase;
      m_run = 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      bit       tv, to;
      int       ev, eo, ed, ec;
      logic [7:0] tc;
      tv = 0; to = 0; tc = 8'h00;
      if (q.size() == LAT) begin
        tv = q[LAT-1][9];
        to = q[LAT-1][8];
        tc = q[LAT-1][7:0];
      end
      ev = tv;
      ed = tv ? {tc[7] ^ fmt_twos, tc[6:0]} : 0;
      eo = (m_busy || to) ? 1 : 0;
      ec = (m_run && (!div2_en || m_phase)) ? 1 : 0;
      check("R1 R7 data_out", data_out, ed);
      check("R2 out_valid", out_valid, ev);
      check("R3 R4 R5 ovr_out", ovr_out, eo);
      check("R6 R8 out_clk_en", out_clk_en, ec);
    end
  end

  // Input stimulus: ramp code, driven 1 ns after the rising edge
  always @(posedge clk) begin
    #1;
    sample_code <= sample_code + 8'd7;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic pull_reset(input int n);
    rst_n = 1'b0;
    #0.2;
    check("R3 immediate ovr on reset", ovr_out, 1);
    check("R6 clock enable frozen", out_clk_en, 0);
    wait_cyc(n);
    rst_n = 1'b1;
  endtask

  initial begin
    #1;
    wait_cyc(3);
    check("R2 reset data zero", data_out, 0);
    check("R3 reset ovr high", ovr_out, 1);
    rst_n = 1'b1;

    // R4 R1: calibration then refill, offset binary
    wait_cyc(CAL + LAT + 20);
    check("R2 valid after refill", out_valid, 1);

    // R7: two's complement
    fmt_twos = 1'b1;
    wait_cyc(20);

    // R5: over-range flag flows with data
    sample_ovr = 1'b1; wait_cyc(3);
    sample_ovr = 1'b0; wait_cyc(LAT + 5);

    // R9: one-cycle request landing on the last calibration cycle
    pull_reset(1);
    wait_cyc(CAL - 1);
    pull_reset(1);
    wait_cyc(CAL - 1);
    check("R9 still calibrating after restart", ovr_out, 1);
    wait_cyc(LAT + 10);

    // R5: sustained over-range across the end of calibration
    sample_ovr = 1'b1;
    pull_reset(2);
    wait_cyc(CAL + 10);
    check("R5 pin held high by over-range", ovr_out, 1);
    sample_ovr = 1'b0;
    wait_cyc(LAT + 5);
    check("R5 pin falls after over-range clears", ovr_out, 0);

    // R8: divide-by-two sample clock
    fmt_twos = 1'b0;
    div2_en = 1'b1;
    pull_reset(2);
    wait_cyc(2 * (CAL + LAT) + 30);
    check("R8 valid after divided refill", out_valid, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule